// File: doc/BRIEF.md
# Loopback Test Pattern Generator and Checker

This block drives a serializer transmit path with one 10-bit test symbol per clock and checks the symbols that return on a loopback receive path. A 3-bit mode code selects the pattern: idle, a constant symbol (all zeros, all ones or alternating bits), a comma pair of opposite disparity, the same comma pair with deliberate corruption, or a PRBS7 stream. A separate enable replaces the selected pattern with a 20-bit user pattern that repeats continuously.

The checker first aligns itself to the incoming stream. Once aligned, it raises a lock flag, compares every received symbol with the symbol it expects and adds the number of differing bits to a saturating error counter. Any change of the mode code or of the pattern enable restarts both sides and clears the counter. The corrupting mode sends a stream with two known bit errors in every 20 bits, so a healthy checker must count errors on a perfect link. This confirms that the checker itself works.

Top module: `lbist_top`

## Requirements
- R1: With mode codes 000 and 001 (and the pattern enable low), the transmit symbol is all zeros, the lock flag stays low and the error counter does not move.
- R2: Code 100 sends 10'h000 on every symbol, code 010 sends 10'h3FF, and code 110 sends 10'h155 (0101010101).
- R3: Code 101 alternates 10'h0FA (0011111010) and 10'h305 (1100000101). The first symbol after the configuration changes is 10'h0FA.
- R4: Code 011 sends the code-101 sequence with bit 0 inverted in both symbols (10'h0FB, 10'h304). The checker still expects the clean sequence, so each compared symbol adds one error on a clean loopback.
- R5: Code 111 sends a PRBS7 stream from x^7+x^6+1, seeded to all ones. Each generator step forms the new bit as state[6] xor state[5] and shifts it into state[0]. Ten steps make one symbol, and the first bit lands in bit 9.
- R6: When the pattern enable is high, the symbols alternate between pattern bits [19:10] and pattern bits [9:0], upper half first after the enable rises. The 20-bit pattern is {hi4, mid8, lo8}. The checker stays unlocked and does not count.
- R7: For constant modes, the checker locks on the first received symbol equal to the expected symbol. For comma modes, it locks on a symbol whose bits [9:1] match either comma symbol. For PRBS, it locks on a symbol whose bits [6:0] are nonzero and loads those bits as the PRBS state. The lock flag rises one clock after that symbol. No symbol is counted until the lock flag is high.
- R8: While locked, each received symbol adds the number of bits that differ from the expected symbol to the counter.
- R9: The 16-bit counter saturates at 16'hFFFF and holds there.
- R10: A change of the mode code or of the pattern enable clears the counter and the lock flag on the next clock.
- R11: After reset, the transmit symbol, the lock flag and the counter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Test pattern code |
| pat_test_en | input | 1 | Send the programmable 20-bit pattern instead |
| pat_hi4 | input | 4 | Pattern bits [19:16] |
| pat_mid8 | input | 8 | Pattern bits [15:8] |
| pat_lo8 | input | 8 | Pattern bits [7:0] |
| tx_sym | output | 10 | Symbol to the serializer |
| rx_sym | input | 10 | Symbol from the loopback deserializer |
| rx_locked | output | 1 | Checker aligned to the received stream |
| err_cnt | output | 16 | Saturating count of mismatched bits |

## Verification
Some rules hold on every cycle, and the assertions check those: the counter never moves while unlocked, never decreases and never grows by more than ten per symbol. They also check that it holds once saturated, that a configuration change clears it and the lock, that idle codes send zeros, and that the comma symbols alternate. Only the bench scenarios can show the exact symbol values. These include the PRBS bit order, the position of the two corrupted bits and the expected error total for a given set of injected bit flips. The same holds for the cycle in which lock is reached.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
   localparam int SYM_W  = 10;
   localparam int PRBS_N = 7;
   localparam int PC_W   = $clog2(SYM_W + 1);

   typedef logic [SYM_W-1:0]  sym_t;
   typedef logic [PRBS_N-1:0] lfsr_t;

   typedef enum logic [2:0] {
      BM_IDLE0 = 3'b000,
      BM_IDLE1 = 3'b001,
      BM_ONES  = 3'b010,
      BM_CPERR = 3'b011,
      BM_ZERO  = 3'b100,
      BM_CPAIR = 3'b101,
      BM_ALT   = 3'b110,
      BM_PRBS  = 3'b111
   } bmode_e;

   typedef struct packed {
      logic       pat_en;
      logic [2:0] mode;
   } cfg_t;

   localparam sym_t COMMA_LO = 10'b0011111010;
   localparam sym_t COMMA_HI = 10'b1100000101;
   localparam sym_t ALT_SYM  = 10'b0101010101;
   localparam sym_t CORR_MSK = 10'b0000000001;

   function automatic sym_t fixed_sym(input logic [2:0] m);
      case (m)
         BM_ONES: return '1;
         BM_ALT:  return ALT_SYM;
         default: return '0;
      endcase
   endfunction

   function automatic sym_t prbs_sym(input lfsr_t s);
      sym_t  r;
      lfsr_t t;
      logic  fb;
      t = s;
      r = '0;
      for (int i = 0; i < SYM_W; i++) begin
         fb = t[PRBS_N-1] ^ t[PRBS_N-2];
         r[SYM_W-1-i] = fb;
         t = {t[PRBS_N-2:0], fb};
      end
      return r;
   endfunction

   function automatic lfsr_t prbs_adv(input lfsr_t s);
      lfsr_t t;
      logic  fb;
      t = s;
      for (int i = 0; i < SYM_W; i++) begin
         fb = t[PRBS_N-1] ^ t[PRBS_N-2];
         t = {t[PRBS_N-2:0], fb};
      end
      return t;
   endfunction

   function automatic logic [PC_W-1:0] popcnt(input sym_t v);
      logic [PC_W-1:0] c;
      c = '0;
      for (int i = 0; i < SYM_W; i++) c = c + PC_W'(v[i]);
      return c;
   endfunction
endpackage

// File: rtl/lbist_tx_gen.sv
module lbist_tx_gen
   import lbist_pkg::*;
#(
   parameter lfsr_t SEED = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  cfg_t               cfg,
   input  logic [2*SYM_W-1:0] pat,
   output sym_t               tx_sym
);
   logic  ph_q, ph_use;
   lfsr_t lf_q, lf_use;
   sym_t  pair_sym, nxt_sym;

   always_comb begin
      ph_use   = restart ? 1'b0 : ph_q;
      lf_use   = restart ? SEED : lf_q;
      pair_sym = ph_use ? COMMA_HI : COMMA_LO;
      if (cfg.pat_en) begin
         nxt_sym = ph_use ? pat[SYM_W-1:0] : pat[2*SYM_W-1:SYM_W];
      end else begin
         case (cfg.mode)
            BM_ZERO, BM_ONES, BM_ALT: nxt_sym = fixed_sym(cfg.mode);
            BM_CPAIR:                 nxt_sym = pair_sym;
            BM_CPERR:                 nxt_sym = pair_sym ^ CORR_MSK;
            BM_PRBS:                  nxt_sym = prbs_sym(lf_use);
            default:                  nxt_sym = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= 1'b0;
         lf_q   <= SEED;
         tx_sym <= '0;
      end else begin
         tx_sym <= nxt_sym;
         ph_q   <= ~ph_use;
         lf_q   <= prbs_adv(lf_use);
      end
   end
endmodule

// File: rtl/lbist_rx_chk.sv
module lbist_rx_chk
   import lbist_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  cfg_t cfg,
   input  sym_t rx_sym,
   output logic locked,
   output logic cmp_en,
   output sym_t miss
);
   logic  lock_q, ph_q, active, acq, hit_lo, hit_hi, is_pair;
   lfsr_t lf_q;
   sym_t  exp_sym;

   always_comb begin
      active  = !cfg.pat_en && (cfg.mode[2:1] != 2'b00);
      is_pair = (cfg.mode == BM_CPAIR) || (cfg.mode == BM_CPERR);
      hit_lo  = rx_sym[SYM_W-1:1] == COMMA_LO[SYM_W-1:1];
      hit_hi  = rx_sym[SYM_W-1:1] == COMMA_HI[SYM_W-1:1];
      if (is_pair) begin
         acq     = hit_lo || hit_hi;
         exp_sym = ph_q ? COMMA_HI : COMMA_LO;
      end else if (cfg.mode == BM_PRBS) begin
         acq     = rx_sym[PRBS_N-1:0] != '0;
         exp_sym = prbs_sym(lf_q);
      end else begin
         acq     = rx_sym == fixed_sym(cfg.mode);
         exp_sym = fixed_sym(cfg.mode);
      end
      miss   = rx_sym ^ exp_sym;
      cmp_en = lock_q && active && !restart;
      locked = lock_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         ph_q   <= 1'b0;
         lf_q   <= '0;
      end else if (restart || !active) begin
         lock_q <= 1'b0;
      end else if (!lock_q) begin
         if (acq) begin
            lock_q <= 1'b1;
            ph_q   <= hit_lo;
            lf_q   <= rx_sym[PRBS_N-1:0];
         end
      end else begin
         ph_q <= ~ph_q;
         lf_q <= prbs_adv(lf_q);
      end
   end
endmodule

// File: rtl/lbist_err_acc.sv
module lbist_err_acc
   import lbist_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add_en,
   input  sym_t             miss,
   output logic [CNT_W-1:0] cnt
);
   logic [CNT_W:0]   sum;
   logic [PC_W-1:0]  inc;

   always_comb begin
      inc = popcnt(miss);
      sum = {1'b0, cnt} + (CNT_W+1)'(inc);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (add_en) begin
         cnt <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/lbist_top.sv
module lbist_top
   import lbist_pkg::*;
#(
   parameter int    CNT_W     = 16,
   parameter lfsr_t PRBS_SEED = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       mode_sel,
   input  logic             pat_test_en,
   input  logic [3:0]       pat_hi4,
   input  logic [7:0]       pat_mid8,
   input  logic [7:0]       pat_lo8,
   output logic [9:0]       tx_sym,
   input  logic [9:0]       rx_sym,
   output logic             rx_locked,
   output logic [CNT_W-1:0] err_cnt
);
   localparam int PAT_W = 2 * SYM_W;

   generate
      if (CNT_W <= PC_W) begin : g_bad_cnt
         $error("lbist_top: CNT_W too small for one symbol of errors");
      end
      if (PRBS_SEED == '0) begin : g_bad_seed
         $error("lbist_top: PRBS_SEED must be nonzero");
      end
      if (PAT_W != 4 + 8 + 8) begin : g_bad_pat
         $error("lbist_top: pattern fields do not fill two symbols");
      end
   endgenerate

   cfg_t             cfg, cfg_q;
   logic             restart, cmp_en;
   logic [PAT_W-1:0] pat;
   sym_t             miss;

   assign cfg     = '{pat_en: pat_test_en, mode: mode_sel};
   assign restart = cfg != cfg_q;
   assign pat     = {pat_hi4, pat_mid8, pat_lo8};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg;
   end

   lbist_tx_gen #(.SEED(PRBS_SEED)) u_gen (
      .clk(clk), .rst_n(rst_n), .restart(restart), .cfg(cfg), .pat(pat), .tx_sym(tx_sym)
   );

   lbist_rx_chk u_chk (
      .clk(clk), .rst_n(rst_n), .restart(restart), .cfg(cfg), .rx_sym(rx_sym),
      .locked(rx_locked), .cmp_en(cmp_en), .miss(miss)
   );

   lbist_err_acc #(.CNT_W(CNT_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(restart), .add_en(cmp_en), .miss(miss), .cnt(err_cnt)
   );
endmodule

// File: rtl/lbist_top_sva.sv
module lbist_top_sva
   import lbist_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             restart,
   input logic [2:0]       mode_sel,
   input logic             pat_test_en,
   input logic [9:0]       tx_sym,
   input logic             rx_locked,
   input logic [CNT_W-1:0] err_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   AST_IDLE_ZERO_TX: assert property (@(posedge clk) disable iff (!rst_n)
      (!pat_test_en && mode_sel[2:1] == 2'b00) |=> (tx_sym == '0 && !rx_locked)); // R1

   AST_COMMA_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!pat_test_en && mode_sel == 3'b101 && !restart && tx_sym == COMMA_LO) |=> tx_sym == COMMA_HI); // R3

   AST_UNLOCKED_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_locked && !restart) |=> $stable(err_cnt)); // R7

   AST_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> err_cnt >= $past(err_cnt)); // R8

   AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> (err_cnt - $past(err_cnt)) <= CNT_W'(SYM_W)); // R8

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt == CNT_MAX && !restart) |=> err_cnt == CNT_MAX); // R9

   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (err_cnt == '0 && !rx_locked)); // R10
endmodule

bind lbist_top lbist_top_sva #(.CNT_W(CNT_W)) u_sva (
   .clk(clk), .rst_n(rst_n), .restart(restart), .mode_sel(mode_sel),
   .pat_test_en(pat_test_en), .tx_sym(tx_sym), .rx_locked(rx_locked), .err_cnt(err_cnt)
);

// File: tb/lbist_top_tb_top.sv
`timescale 1ns/1ps
module lbist_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_sel = 3'b000;
   logic        pat_test_en = 1'b0;
   logic [3:0]  pat_hi4 = 4'h0;
   logic [7:0]  pat_mid8 = 8'h03;
   logic [7:0]  pat_lo8 = 8'hFF;
   logic [9:0]  tx_sym;
   logic [9:0]  flip = '0;
   logic [9:0]  rx_sym;
   logic        rx_locked;
   logic [15:0] err_cnt;

   int total = 0;
   int bad   = 0;
   logic       cur_pe = 1'b0;
   logic [2:0] cur_md = 3'b000;

   always #2.5 clk = ~clk;
   assign rx_sym = tx_sym ^ flip;

   lbist_top dut_i (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pat_test_en(pat_test_en),
      .pat_hi4(pat_hi4), .pat_mid8(pat_mid8), .pat_lo8(pat_lo8), .tx_sym(tx_sym),
      .rx_sym(rx_sym), .rx_locked(rx_locked), .err_cnt(err_cnt)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // k-th PRBS symbol after restart, bit-serial from the all-ones seed (R5)
   function automatic logic [9:0] ref_prbs(input int k);
      logic [6:0] s = 7'h7F;
      logic [9:0] r = '0;
      logic       b;
      for (int i = 0; i < (k + 1) * 10; i++) begin
         b = s[6] ^ s[5];
         s = {s[5:0], b};
         r = {r[8:0], b};
      end
      return r;
   endfunction

   function automatic logic [9:0] ref_tx(input logic pe, input logic [2:0] md,
                                         input logic [19:0] pt, input int k);
      if (pe) return (k % 2 == 0) ? pt[19:10] : pt[9:0];
      case (md)
         3'b100: return 10'h000;
         3'b010: return 10'h3FF;
         3'b110: return 10'h155;
         3'b101: return (k % 2 == 0) ? 10'h0FA : 10'h305;
         3'b011: return (k % 2 == 0) ? 10'h0FB : 10'h304;
         3'b111: return ref_prbs(k);
         default: return 10'h000;
      endcase
   endfunction

   function automatic string tx_tag(input logic pe, input logic [2:0] md);
      if (pe) return "R6";
      case (md)
         3'b100, 3'b010, 3'b110: return "R2";
         3'b101: return "R3";
         3'b011: return "R4";
         3'b111: return "R5";
         default: return "R1";
      endcase
   endfunction

   // fm: 0 clean loopback, 1 random bit flips, 2 every bit flipped
   task automatic run_seg(input logic pe, input logic [2:0] md, input logic [19:0] pt,
                          input int len, input int fm);
      logic        act;
      logic [9:0]  corr;
      logic [31:0] exp_cnt;
      string       ctag;
      if (pe == cur_pe && md == cur_md) begin
         pat_test_en = 1'b0;
         mode_sel    = (md == 3'b001 && !pe) ? 3'b000 : 3'b001;
         @(posedge clk); @(negedge clk);
      end
      pat_test_en = pe;
      mode_sel    = md;
      {pat_hi4, pat_mid8, pat_lo8} = pt;
      cur_pe = pe;
      cur_md = md;
      flip   = '0;
      act     = !pe && (md[2:1] != 2'b00);
      corr    = (!pe && md == 3'b011) ? 10'h001 : 10'h000;
      exp_cnt = 0;
      ctag    = (fm == 2) ? "R9" : (fm == 1) ? "R8" : (corr != 0) ? "R4" : "R7";
      for (int k = 0; k < len; k++) begin
         @(posedge clk); @(negedge clk);
         if (act && k >= 2) begin
            exp_cnt = exp_cnt + $countones(flip ^ corr);
            if (exp_cnt > 32'hFFFF) exp_cnt = 32'hFFFF;
         end
         chk(tx_tag(pe, md), {22'd0, tx_sym}, {22'd0, ref_tx(pe, md, pt, k)});
         if (k == 0) begin
            chk("R10 lock cleared", {31'd0, rx_locked}, 32'd0);
            chk("R10 count cleared", {16'd0, err_cnt}, 32'd0);
         end else begin
            chk("R7 lock", {31'd0, rx_locked}, {31'd0, act});
            chk(pe ? "R6 count" : (act ? ctag : "R1 count"), {16'd0, err_cnt}, exp_cnt);
         end
         if (act && k >= 1 && fm == 2) flip = 10'h3FF;
         else if (act && k >= 1 && fm == 1) flip = ($urandom % 3 == 0) ? 10'($urandom_range(1, 1023)) : 10'h000;
         else flip = '0;
      end
      flip = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk("R11 tx", {22'd0, tx_sym}, 32'd0);
      chk("R11 lock", {31'd0, rx_locked}, 32'd0);
      chk("R11 count", {16'd0, err_cnt}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      run_seg(1'b0, 3'b001, 20'h003FF, 6, 0);     // R1
      run_seg(1'b0, 3'b100, 20'h003FF, 8, 0);     // R2
      run_seg(1'b0, 3'b010, 20'h003FF, 8, 0);     // R2
      run_seg(1'b0, 3'b110, 20'h003FF, 8, 0);     // R2
      run_seg(1'b0, 3'b101, 20'h003FF, 12, 0);    // R3
      run_seg(1'b0, 3'b011, 20'h003FF, 20, 0);    // R4
      run_seg(1'b0, 3'b111, 20'h003FF, 30, 0);    // R5
      run_seg(1'b1, 3'b111, 20'h003FF, 8, 0);     // R6 default pattern
      run_seg(1'b1, 3'b000, 20'hA5C3E, 8, 0);     // R6
      run_seg(1'b0, 3'b111, 20'h003FF, 40, 1);    // R8
      run_seg(1'b0, 3'b011, 20'h003FF, 40, 1);    // R4, R8
      run_seg(1'b0, 3'b000, 20'h003FF, 6, 0);     // R1 after errors, R10

      for (int n = 0; n < 40; n++) begin
         logic        pe = ($urandom % 4 == 0);
         logic [2:0]  md = 3'($urandom_range(0, 7));
         logic [19:0] pt = 20'($urandom);
         run_seg(pe, md, pt, $urandom_range(3, 40), $urandom_range(0, 1));
      end

      run_seg(1'b0, 3'b100, 20'h003FF, 6560, 2);  // R9 saturation

      // R11 reset in the middle of a run
      run_seg(1'b0, 3'b011, 20'h003FF, 10, 0);
      rst_n = 1'b0;
      mode_sel = 3'b000;
      cur_md = 3'b000;
      cur_pe = 1'b0;
      pat_test_en = 1'b0;
      @(negedge clk);
      chk("R11 tx", {22'd0, tx_sym}, 32'd0);
      chk("R11 lock", {31'd0, rx_locked}, 32'd0);
      chk("R11 count", {16'd0, err_cnt}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      run_seg(1'b0, 3'b101, 20'h003FF, 10, 0);    // R3 after reset

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule